// File: doc/BRIEF.md
# SPI Master with Output-Enable Framing

This block sends and receives one serial frame at a time as the master of a four-wire serial link. It handles all four combinations of clock polarity and clock phase and any frame length from 4 to 32 bits. The data line is sent most significant bit first. Alongside the usual clock, data and select lines, the block drives an active-low output-enable line. That line brackets the driven data with a half serial-clock margin before the first clock edge and after the last one.

The host presents a transmit word, a frame length and the two mode bits, then raises `start_i` for one cycle. The block then runs the frame on its own, with the serial clock derived from the system clock through a fixed even divider. When the frame ends it returns the received word right-aligned to the programmed length and raises `done_o` for one cycle. A new start is accepted only when the block is idle.

Top module: `spi_oe_master`

## Requirements
- R1: Out of reset and while idle, `ss_no` and `doe_no` are 1, `busy_o`, `done_o` and `mosi_o` are 0, `rx_data_o` is 0 until the first frame completes, and `sclk_o` equals the `cpol_i` value sampled on the previous clock edge.
- R2: A `start_i` sampled high while idle is accepted on that edge. In the next cycle `ss_no` and `doe_no` are both 0 and `busy_o` is 1. `sclk_o` then stays at the idle level for CLK_DIV/2 cycles before its first edge (setup margin).
- R3: A frame of L bits has exactly 2·L serial-clock edges, spaced CLK_DIV/2 system cycles apart. The first edge leaves the idle level and the clock ends at the idle level. `sclk_o` changes during a transfer only while `doe_no` is 0.
- R4: The mode is {`cpol_i`,`cpha_i`}: modes 0 to 3 are 00, 01, 10 and 11. With `cpol_i`=0 the clock idles low, and with 1 it idles high. With `cpha_i`=0, `miso_i` is sampled on odd-numbered (leading) edges and the output advances on even-numbered (trailing) edges. With `cpha_i`=1, the output advances on leading edges other than the first, and sampling happens on trailing edges.
- R5: `mosi_o` carries the low L bits of the transmit word, bit L-1 first and bit 0 last. It is held at 0 whenever `doe_no` is 1.
- R6: `frame_len_i` is the bit count as a plain binary value. Values below 4 are treated as 4, and values above DATA_W (32) are treated as DATA_W.
- R7: `doe_no` rises CLK_DIV/2 cycles after the last clock edge (hold margin). `ss_no` rises CLK_DIV/2 cycles after that, in the same cycle as a single-cycle `done_o` pulse, with `busy_o` back at 0.
- R8: In the `done_o` cycle, `rx_data_o` holds the L received bits right-aligned (first received bit at position L-1) with all upper bits 0. It keeps that value until the next `done_o`.
- R9: `start_i` and all frame inputs are ignored while `busy_o` is 1. The running frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| tx_data_i | input | DATA_W | Word to transmit, right-aligned |
| frame_len_i | input | LEN_W | Frame length in bits |
| cpol_i | input | 1 | Clock polarity (idle level) |
| cpha_i | input | 1 | Clock phase |
| miso_i | input | 1 | Serial data from the slave |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| rx_data_o | output | DATA_W | Received word, right-aligned |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| doe_no | output | 1 | Data output enable, active low |
| ss_no | output | 1 | Slave select, active low |

## Verification
The assertions take for granted that CLK_DIV is even and at least 2. They also assume that, while idle, `cpol_i` changes only through a frame's setup, so any clock movement seen with `busy_o` high is matched by an asserted enable. The bench keeps the mode bits fixed while a frame runs and changes them only together with a start. Its slave model drives `miso_i` at the falling system-clock edge that follows each observed serial-clock edge, which keeps the sampled data well defined at every capture. Starts issued mid-frame carry a different word and length, and the bench checks that they are ignored.

// File: rtl/spi_oe_pkg.sv
package spi_oe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/spi_oe_tick.sv
module spi_oe_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_oe_seq.sv
module spi_oe_seq
  import spi_oe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             load_o,
  output logic [LEN_W-1:0] len_o,
  output logic             sample_o,
  output logic             shift_o,
  output logic             capture_o,
  output logic             sclk_o,
  output logic             ss_no,
  output logic             doe_no,
  output logic             done_o
);
  localparam int EDGE_W = LEN_W + 1;

  seq_state_e       state_q;
  logic [EDGE_W-1:0] edge_q;
  logic [LEN_W-1:0] len_q;
  logic             cpha_q;
  logic             sclk_q, ss_q, doe_q, done_q;
  logic             edge_go, leading, last_edge;

  always_comb begin
    if (frame_len_i < LEN_W'(MIN_LEN))     len_o = LEN_W'(MIN_LEN);
    else if (frame_len_i > LEN_W'(DATA_W)) len_o = LEN_W'(DATA_W);
    else                                   len_o = frame_len_i;
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign edge_go   = tick_i && (state_q == ST_SHIFT);
  assign leading   = ~edge_q[0];  // next edge number is odd
  assign last_edge = (edge_q == ({len_q, 1'b0} - 1'b1));
  assign sample_o  = edge_go && (cpha_q ? ~leading : leading);
  assign shift_o   = edge_go && (cpha_q ? (leading && (edge_q != '0)) : ~leading);
  assign capture_o = tick_i && (state_q == ST_TAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      len_q   <= LEN_W'(MIN_LEN);
      cpha_q  <= 1'b0;
      sclk_q  <= 1'b0;
      ss_q    <= 1'b1;
      doe_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= cpol_i;
          if (start_i) begin
            state_q <= ST_SHIFT;
            edge_q  <= '0;
            len_q   <= len_o;
            cpha_q  <= cpha_i;
            ss_q    <= 1'b0;
            doe_q   <= 1'b0;
          end
        end
        ST_SHIFT: if (tick_i) begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
          if (last_edge) state_q <= ST_HOLD;
        end
        ST_HOLD: if (tick_i) begin
          doe_q   <= 1'b1;
          state_q <= ST_TAIL;
        end
        ST_TAIL: if (tick_i) begin
          ss_q    <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;
  assign ss_no  = ss_q;
  assign doe_no = doe_q;
  assign done_o = done_q;
endmodule

// File: rtl/spi_oe_shifter.sv
module spi_oe_shifter #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              capture_i,
  input  logic              miso_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [DATA_W-1:0] tx_q, rx_q, rx_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      rx_q     <= '0;
      rx_out_q <= '0;
    end else begin
      if (load_i) begin
        // left-align so the frame MSB sits at the top bit
        tx_q <= tx_data_i << (LEN_W'(DATA_W) - len_i);
        rx_q <= '0;
      end else begin
        if (shift_i)  tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        if (sample_i) rx_q <= {rx_q[DATA_W-2:0], miso_i};
      end
      if (capture_i) rx_out_q <= rx_q;
    end
  end

  assign tx_bit_o  = tx_q[DATA_W-1];
  assign rx_data_o = rx_out_q;
endmodule

// File: rtl/spi_oe_master.sv
module spi_oe_master #(
  parameter int DATA_W  = 32,
  parameter int CLK_DIV = 4,
  parameter int MIN_LEN = 4,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              doe_no,
  output logic              ss_no
);
  localparam int HALF = CLK_DIV / 2;

  logic             tick, load, sample, shift, capture, tx_bit;
  logic [LEN_W-1:0] len_c;

  spi_oe_tick #(.HALF(HALF)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  spi_oe_seq #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .frame_len_i (frame_len_i),
    .cpol_i      (cpol_i),
    .cpha_i      (cpha_i),
    .tick_i      (tick),
    .busy_o      (busy_o),
    .load_o      (load),
    .len_o       (len_c),
    .sample_o    (sample),
    .shift_o     (shift),
    .capture_o   (capture),
    .sclk_o      (sclk_o),
    .ss_no       (ss_no),
    .doe_no      (doe_no),
    .done_o      (done_o)
  );

  spi_oe_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .len_i     (len_c),
    .tx_data_i (tx_data_i),
    .sample_i  (sample),
    .shift_i   (shift),
    .capture_i (capture),
    .miso_i    (miso_i),
    .tx_bit_o  (tx_bit),
    .rx_data_o (rx_data_o)
  );

  assign mosi_o = tx_bit & ~doe_no;
endmodule

// File: rtl/spi_oe_master_chk.sv
module spi_oe_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic doe_no,
  input logic ss_no
);
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ss_no && doe_no));

  a_r2_enable_with_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(doe_no) |-> $fell(ss_no));

  a_r3_clock_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable(sclk_o)) |-> !doe_no);

  a_r5_quiet_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doe_no |-> !mosi_o);

  a_r7_enable_before_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(doe_no) |-> !ss_no);

  a_r7_done_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($rose(ss_no) && !busy_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind spi_oe_master spi_oe_master_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .done_o (done_o),
  .sclk_o (sclk_o),
  .mosi_o (mosi_o),
  .doe_no (doe_no),
  .ss_no  (ss_no)
);

// File: tb/test_spi_oe_master.sv
`timescale 1ns/1ps
module test_spi_oe_master;
  localparam int DATA_W  = 32;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int LEN_W   = $clog2(DATA_W + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [DATA_W-1:0] tx_data_i = '0;
  logic [LEN_W-1:0]  frame_len_i = LEN_W'(8);
  logic              cpol_i = 1'b0;
  logic              cpha_i = 1'b0;
  logic              miso_i = 1'b0;
  logic              busy_o, done_o, sclk_o, mosi_o, doe_no, ss_no;
  logic [DATA_W-1:0] rx_data_o;

  always #2 clk_i = ~clk_i;

  spi_oe_master #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) i_spi_oe_master (
    .clk_i, .rst_ni, .start_i, .tx_data_i, .frame_len_i, .cpol_i, .cpha_i,
    .miso_i, .busy_o, .done_o, .rx_data_o, .sclk_o, .mosi_o, .doe_no, .ss_no
  );

  int n_chk = 0, n_err = 0, frames = 0;
  bit finished = 0;
  logic [DATA_W-1:0] slave_word = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: frame timeline in half-period ticks plus a reactive slave
  bit          m_active = 0, m_pend = 0, m_cpol = 0, m_cpha = 0, prev_cpol = 0, m_sclk_seen = 0;
  int          m_n = 0, m_len = 4, m_e = 0;
  logic [31:0] m_tx = '0, m_sw = '0;
  logic [63:0] exp_rx = '0;

  function automatic int clamp_len(input int v);
    if (v < 4) return 4;
    if (v > DATA_W) return DATA_W;
    return v;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      int k, kc, s;
      bit e_busy, e_ss, e_doe, e_done, e_sclk, e_mosi;
      if (m_active) begin
        m_n++;
        if (sclk_o !== m_sclk_seen) begin m_e++; m_sclk_seen = sclk_o; end
      end
      if (m_pend) begin
        m_active = 1; m_pend = 0; m_n = 0; m_e = 0; m_sclk_seen = sclk_o;
      end
      if (m_active) begin
        k  = m_n / HALF;
        kc = (k > 2*m_len) ? 2*m_len : k;
        e_busy = (k < 2*m_len + 2);
        e_ss   = (k >= 2*m_len + 2);
        e_doe  = (k >= 2*m_len + 1);
        e_done = (k == 2*m_len + 2);
        e_sclk = m_cpol ^ kc[0];
        s = m_cpha ? ((kc == 0) ? 0 : (kc - 1) / 2) : kc / 2;
        e_mosi = (!e_doe && s < m_len) ? m_tx[m_len-1-s] : 1'b0;
        if (e_done) exp_rx = {32'd0, m_sw} & ((64'd1 << m_len) - 64'd1);
      end else begin
        e_busy = 0; e_ss = 1; e_doe = 1; e_done = 0; e_sclk = prev_cpol; e_mosi = 0;
      end
      chk(busy_o === e_busy, "R9 busy",   64'(busy_o), 64'(e_busy));
      chk(ss_no  === e_ss,   "R2 select", 64'(ss_no),  64'(e_ss));
      chk(doe_no === e_doe,  "R7 enable", 64'(doe_no), 64'(e_doe));
      chk(done_o === e_done, "R7 done",   64'(done_o), 64'(e_done));
      chk(sclk_o === e_sclk, m_active ? "R3 sclk" : "R1 idle sclk", 64'(sclk_o), 64'(e_sclk));
      chk(mosi_o === e_mosi, "R5 mosi",   64'(mosi_o), 64'(e_mosi));
      chk(64'(rx_data_o) === exp_rx, "R8 rx", 64'(rx_data_o), exp_rx);
      if (m_active && e_done) begin
        chk(m_e == 2*m_len, "R6 edge count", 64'(m_e), 64'(2*m_len));
        chk(64'(rx_data_o) === exp_rx, "R4 mode capture", 64'(rx_data_o), exp_rx);
        m_active = 0;
        frames++;
      end
      if (!m_active && start_i) begin
        m_pend = 1; m_tx = tx_data_i; m_sw = slave_word;
        m_len = clamp_len(int'(frame_len_i)); m_cpol = cpol_i; m_cpha = cpha_i;
      end
      // slave: next bit after observed edges
      if (m_active) begin
        s = m_cpha ? ((m_e == 0) ? 0 : (m_e - 1) / 2) : m_e / 2;
        miso_i <= (s < m_len) ? m_sw[m_len-1-s] : 1'b0;
      end
      prev_cpol = cpol_i;
    end
  end

  task automatic frame(input logic [31:0] tx, input logic [31:0] sw, input int len,
                       input bit pol, input bit pha, input bit poke);
    @(posedge clk_i); #1;
    tx_data_i = tx; frame_len_i = LEN_W'(len); cpol_i = pol; cpha_i = pha;
    slave_word = sw; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0; tx_data_i = ~tx;
    if (poke) begin  // R9: start while busy must be ignored
      repeat (7) @(posedge clk_i); #1;
      start_i = 1'b1; frame_len_i = LEN_W'(5); tx_data_i = 32'hDEAD_BEEF;
      @(posedge clk_i); #1;
      start_i = 1'b0;
    end
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(ss_no === 1'b1 && doe_no === 1'b1, "R1 reset lines", {ss_no, doe_no}, 2'b11);
    chk(busy_o === 1'b0 && done_o === 1'b0 && mosi_o === 1'b0, "R1 reset flags",
        {busy_o, done_o, mosi_o}, 0);
    chk(rx_data_o === '0 && sclk_o === 1'b0, "R1 reset data", 64'(rx_data_o), 0);
    @(posedge clk_i); #1; rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);

    frame(32'h0000_00A5, 32'h0000_003C, 8,  0, 0, 0);  // R4 mode 0
    frame(32'h0000_005A, 32'h0000_00C3, 8,  0, 1, 0);  // R4 mode 1
    frame(32'h0000_0096, 32'h0000_0069, 8,  1, 0, 0);  // R4 mode 2
    frame(32'h0000_00F1, 32'h0000_001E, 8,  1, 1, 0);  // R4 mode 3
    frame(32'h0000_0009, 32'h0000_0006, 4,  0, 1, 0);  // R6 minimum length
    frame(32'h8000_0001, 32'hF0E1_D2C3, 32, 1, 0, 0);  // R6 maximum length
    frame(32'h0000_1ABC, 32'h0000_0F0F, 13, 1, 1, 1);  // R9 ignored start
    frame(32'hFFFF_FFF5, 32'hFFFF_FFFA, 2,  0, 0, 0);  // R6 clamp up to 4
    frame(32'h1234_5678, 32'h9ABC_DEF0, 40, 1, 1, 0);  // R6 clamp down to 32
    frame(32'h0000_0015, 32'h0000_000B, 5,  0, 0, 0);  // back-to-back start
    frame(32'h0000_0002, 32'h0000_001D, 5,  1, 0, 0);
    repeat (4) @(negedge clk_i);
    chk(frames == 11, "R7 frame count", 64'(frames), 11);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R7: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule